// File: doc/BRIEF.md
# Warp memory access coalescer

The block takes one warp-wide load request, made of 32 lane byte addresses and a mask of active lanes. It sorts the active lanes into naturally aligned 128-byte segments. For each segment it issues a single memory transaction, sized 32, 64 or 128 bytes. When a warp's addresses are contiguous and aligned, one request becomes one transaction. When the lanes are spread across many segments, the request becomes up to 32 transactions, one per segment.

A request is taken in with a valid/ready handshake and held internally. Transactions then leave through a second valid/ready handshake, at most one per cycle, in ascending order of segment address. Each transaction carries a base address, a size code and a mask of the lanes it serves. A one-cycle done pulse follows the final transaction, and after that the block accepts the next request.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready_o` is high only while the block is idle. It goes low in the cycle after a request is accepted and stays low until the done pulse has passed. For a request with at least one active lane, `txn_valid_o` rises in the cycle after acceptance, and `req_ready_o` and `txn_valid_o` are never high together.
- R2: If 32 active lanes read consecutive 4-byte words that fill one aligned 128-byte segment, exactly one transaction is issued: base equal to the segment start, size code 2, lane mask all ones.
- R3: The size code is 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes. The chosen size is the smallest of the three whose aligned block holds every lane of that segment:
  - 32 bytes if all those lanes fall in one aligned 32-byte block.
  - Otherwise 64 bytes if they fall in one aligned 64-byte half of the segment.
  - Otherwise 128 bytes.

  The base is always aligned to the chosen size.
- R4: Each distinct 128-byte segment touched by active lanes gets exactly one transaction. Under a 128-byte stride, this gives 32 one-lane transactions.
- R5: Within a request, transactions appear in strictly ascending base address order, whatever the order of the lanes.
- R6: Inactive lanes do not influence any transaction. A request with an empty active mask produces no transaction, and `done_o` pulses in the cycle after acceptance.
- R7: Lanes in the same segment, including lanes with identical addresses, share one transaction and are all set in its lane mask. No lane appears in two transactions.
- R8: While `txn_valid_o` is high and `txn_ready_i` is low, the transaction stays valid and its base, size and lane mask stay unchanged.
- R9: `done_o` is a single-cycle pulse in the cycle after the final transaction handshake. In the following cycle, `req_ready_o` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (idle) |
| req_active_i | input | 32 | Active lane mask |
| req_addr_i | input | 1024 | Lane byte addresses, lane n at bits [32n+31:32n] |
| txn_valid_o | output | 1 | Transaction valid |
| txn_ready_i | input | 1 | Transaction ready |
| txn_base_o | output | 32 | Transaction base byte address |
| txn_size_o | output | 2 | Size code: 0=32 B, 1=64 B, 2=128 B |
| txn_lanes_o | output | 32 | Lanes served by this transaction |
| done_o | output | 1 | One-cycle pulse after the last transaction |

## Verification
- **First transaction:** a request accepted at a clock edge shows its first transaction before the next edge, through one state register.
- **Issue rate:** with ready held high, each further transaction follows one cycle after the previous one.
- **Done pulse:** `done_o` appears in the cycle after the final handshake, and in the cycle after acceptance for an empty mask.
- **How the checks keep to this:** the bench changes inputs and reads outputs only on falling edges, and numbers each falling edge from acceptance. It records the cycle of the first valid transaction and the cycle of done, and compares both with these counts. Under stalled ready, it compares the held outputs one falling edge later.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int SEG_LOG2 = 7;
  localparam int SUB_LOG2 = 5;
  localparam int NSUB     = 1 << (SEG_LOG2 - SUB_LOG2);
  localparam int SUB_W    = SEG_LOG2 - SUB_LOG2;

  typedef enum logic [1:0] {
    SZ_32  = 2'd0,
    SZ_64  = 2'd1,
    SZ_128 = 2'd2
  } txn_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } coal_state_e;
endpackage

// File: rtl/coal_seg_pick.sv
module coal_seg_pick #(
  parameter int LANES = 32,
  parameter int SEGW  = 25
) (
  input  logic [LANES-1:0]           pend_i,
  input  logic [LANES-1:0][SEGW-1:0] seg_i,
  output logic [SEGW-1:0]            seg_o,
  output logic [LANES-1:0]           match_o
);
  logic found;

  always_comb begin
    found = 1'b0;
    seg_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (pend_i[i] && (!found || seg_i[i] < seg_o)) begin
        seg_o = seg_i[i];
        found = 1'b1;
      end
    end
    for (int i = 0; i < LANES; i++) begin
      match_o[i] = pend_i[i] && (seg_i[i] == seg_o);
    end
  end
endmodule

// File: rtl/coal_size_sel.sv
module coal_size_sel
  import coal_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0]            match_i,
  input  logic [LANES-1:0][SUB_W-1:0] sub_i,
  output txn_size_e                   size_o,
  output logic [SEG_LOG2-1:0]         off_o
);
  logic [NSUB-1:0]          used;
  logic [$clog2(NSUB+1)-1:0] cnt;
  logic [SUB_W-1:0]         idx;
  logic                     lo_half, hi_half;

  always_comb begin
    used = '0;
    for (int i = 0; i < LANES; i++) begin
      if (match_i[i]) used[sub_i[i]] = 1'b1;
    end
    cnt = '0;
    idx = '0;
    for (int j = 0; j < NSUB; j++) begin
      if (used[j]) begin
        cnt = cnt + 1'b1;
        idx = SUB_W'(j);
      end
    end
    lo_half = |used[NSUB/2-1:0];
    hi_half = |used[NSUB-1:NSUB/2];
    if (cnt == 1) begin
      size_o = SZ_32;
      off_o  = {idx, {SUB_LOG2{1'b0}}};
    end else if (!(lo_half && hi_half)) begin
      size_o = SZ_64;
      off_o  = {hi_half, {(SEG_LOG2-1){1'b0}}};
    end else begin
      size_o = SZ_128;
      off_o  = '0;
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [LANES-1:0]  req_active_i,
  input  logic [LANES*AW-1:0] req_addr_i,
  output logic              txn_valid_o,
  input  logic              txn_ready_i,
  output logic [AW-1:0]     txn_base_o,
  output logic [1:0]        txn_size_o,
  output logic [LANES-1:0]  txn_lanes_o,
  output logic              done_o
);
  localparam int SEGW = AW - SEG_LOG2;

  coal_state_e                  state_q;
  logic [LANES-1:0]             pend_q;
  logic [LANES-1:0][SEGW-1:0]   seg_q;
  logic [LANES-1:0][SUB_W-1:0]  sub_q;
  logic [LANES-1:0][SUB_LOG2-1:0] lo_bits;
  logic                         unused_lo;

  logic [SEGW-1:0]              cur_seg;
  logic [LANES-1:0]             cur_match;
  txn_size_e                    cur_size;
  logic [SEG_LOG2-1:0]          cur_off;
  logic                         accept, fire;
  logic [LANES-1:0]             pend_left;

  for (genvar l = 0; l < LANES; l++) begin : g_lo
    assign lo_bits[l] = req_addr_i[l*AW +: SUB_LOG2];
  end
  assign unused_lo = ^lo_bits;

  coal_seg_pick #(.LANES(LANES), .SEGW(SEGW)) u_pick (
    .pend_i  (pend_q),
    .seg_i   (seg_q),
    .seg_o   (cur_seg),
    .match_o (cur_match)
  );

  coal_size_sel #(.LANES(LANES)) u_size (
    .match_i (cur_match),
    .sub_i   (sub_q),
    .size_o  (cur_size),
    .off_o   (cur_off)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign txn_valid_o = (state_q == ST_RUN);
  assign done_o      = (state_q == ST_FIN);
  assign txn_base_o  = {cur_seg, cur_off};
  assign txn_size_o  = cur_size;
  assign txn_lanes_o = cur_match;
  assign accept      = req_valid_i && req_ready_o;
  assign fire        = txn_valid_o && txn_ready_i;
  assign pend_left   = pend_q & ~cur_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      seg_q   <= '0;
      sub_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          pend_q  <= req_active_i;
          state_q <= (req_active_i == '0) ? ST_FIN : ST_RUN;
          for (int l = 0; l < LANES; l++) begin
            seg_q[l] <= req_addr_i[l*AW+SEG_LOG2 +: SEGW];
            sub_q[l] <= req_addr_i[l*AW+SUB_LOG2 +: SUB_W];
          end
        end
        ST_RUN: if (fire) begin
          pend_q <= pend_left;
          if (pend_left == '0) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             txn_valid_o,
  input logic             txn_ready_i,
  input logic [AW-1:0]    txn_base_o,
  input logic [1:0]       txn_size_o,
  input logic [LANES-1:0] txn_lanes_o,
  input logic             done_o
);
  logic fire;
  assign fire = txn_valid_o && txn_ready_i;

  a_r1_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  a_r1_ready_valid_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && txn_valid_o));
  a_r3_size_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_size_o != 2'd3);
  a_r3_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> ((txn_size_o == 2'd0 && txn_base_o[4:0] == '0) ||
                     (txn_size_o == 2'd1 && txn_base_o[5:0] == '0) ||
                     (txn_size_o == 2'd2 && txn_base_o[6:0] == '0)));
  a_r4_lanes_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_lanes_o != '0);
  a_r5_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !txn_valid_o || (txn_base_o > $past(txn_base_o)));
  a_r7_lanes_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !txn_valid_o || ((txn_lanes_o & $past(txn_lanes_o)) == '0));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_base_o) &&
      $stable(txn_size_o) && $stable(txn_lanes_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);
endmodule

bind warp_coalescer coal_chk #(.LANES(LANES), .AW(AW)) u_coal_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .txn_valid_o (txn_valid_o),
  .txn_ready_i (txn_ready_i),
  .txn_base_o  (txn_base_o),
  .txn_size_o  (txn_size_o),
  .txn_lanes_o (txn_lanes_o),
  .done_o      (done_o)
);

// File: tb/warp_coalescer_bench.sv
`timescale 1ns/1ps
module warp_coalescer_bench;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [LANES-1:0] req_active = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic txn_valid;
  logic txn_ready = 1'b0;
  logic [AW-1:0] txn_base;
  logic [1:0] txn_size;
  logic [LANES-1:0] txn_lanes;
  logic done;

  always #4 clk = ~clk;

  warp_coalescer #(.LANES(LANES), .AW(AW)) u_warp_coalescer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_active_i(req_active), .req_addr_i(req_addr), .txn_valid_o(txn_valid),
    .txn_ready_i(txn_ready), .txn_base_o(txn_base), .txn_size_o(txn_size),
    .txn_lanes_o(txn_lanes), .done_o(done)
  );

  int vectors = 0;
  int miscompares = 0;

  logic [AW-1:0] addr_v [LANES];
  logic [AW-1:0] got_base [64];
  logic [1:0] got_size [64];
  logic [LANES-1:0] got_lanes [64];
  int got_n, first_v, done_c;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [LANES-1:0] act, input int mode);
    logic hold;
    logic [AW-1:0] h_base;
    logic [1:0] h_size;
    logic [LANES-1:0] h_lanes;
    hold = 1'b0; h_base = '0; h_size = '0; h_lanes = '0;
    got_n = 0; first_v = -1; done_c = -1;
    @(negedge clk);
    req_valid = 1'b1;
    req_active = act;
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = addr_v[l];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c < 200 && done_c < 0; c++) begin
      txn_ready = (mode == 0) || c[0];
      if (c == 1) chk(req_ready == 1'b0, "R1", "ready low after accept", req_ready, 0);
      if (hold) begin
        chk(txn_valid && txn_base == h_base && txn_size == h_size && txn_lanes == h_lanes,
            "R8", "held transaction", txn_base, h_base);
        hold = 1'b0;
      end
      if (txn_valid) begin
        if (first_v < 0) first_v = c;
        if (txn_ready) begin
          if (got_n < 64) begin
            got_base[got_n] = txn_base;
            got_size[got_n] = txn_size;
            got_lanes[got_n] = txn_lanes;
          end
          got_n++;
        end else begin
          hold = 1'b1; h_base = txn_base; h_size = txn_size; h_lanes = txn_lanes;
        end
      end
      if (done) done_c = c;
      @(negedge clk);
    end
    txn_ready = 1'b0;
    chk(!done && req_ready, "R9", "done single cycle, ready back", {done, req_ready}, 1);
  endtask

  task automatic chk_one(input string req, input logic [AW-1:0] b, input logic [1:0] s,
                         input logic [LANES-1:0] ln);
    chk(got_n == 1, req, "transaction count", got_n, 1);
    chk(got_base[0] == b, req, "base", got_base[0], b);
    chk(got_size[0] == s, req, "size", got_size[0], s);
    chk(got_lanes[0] == ln, req, "lanes", got_lanes[0], ln);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(txn_valid == 1'b0, "R1", "reset txn_valid", txn_valid, 0);
    chk(done == 1'b0, "R9", "reset done", done, 0);
  endtask

  task automatic t_contig;
    for (int l = 0; l < LANES; l++) addr_v[l] = 32'h1000 + 4*l;
    run_req('1, 0);
    chk_one("R2", 32'h1000, 2'd2, '1);
    chk(first_v == 1, "R1", "first valid cycle", first_v, 1);
    chk(done_c == 2, "R9", "done cycle", done_c, 2);
  endtask

  task automatic t_sizes;
    for (int l = 0; l < LANES; l++) addr_v[l] = 32'h2040 + 4*l;
    run_req(32'h0000_00FF, 0);
    chk_one("R3", 32'h2040, 2'd0, 32'h0000_00FF);
    for (int l = 0; l < LANES; l++) addr_v[l] = 32'h3040 + 4*l;
    run_req(32'h0000_FFFF, 0);
    chk_one("R3", 32'h3040, 2'd1, 32'h0000_FFFF);
    addr_v[0] = 32'h4000; addr_v[1] = 32'h4060;
    run_req(32'h3, 0);
    chk_one("R3", 32'h4000, 2'd2, 32'h3);
    addr_v[0] = 32'h5020; addr_v[1] = 32'h5040;
    run_req(32'h3, 0);
    chk_one("R3", 32'h5000, 2'd2, 32'h3);
  endtask

  task automatic t_scatter;
    bit ok_b, ok_s, ok_l;
    for (int l = 0; l < LANES; l++) addr_v[l] = 32'h10000 + (31 - l) * 128;
    run_req('1, 1);
    chk(got_n == 32, "R4", "scattered count", got_n, 32);
    ok_b = 1; ok_s = 1; ok_l = 1;
    for (int k = 0; k < 32 && k < got_n; k++) begin
      if (got_base[k] != 32'h10000 + k*128) ok_b = 0;
      if (got_size[k] != 2'd0) ok_s = 0;
      if (got_lanes[k] != (32'h1 << (31 - k))) ok_l = 0;
    end
    chk(ok_b, "R5", "ascending bases", ok_b, 1);
    chk(ok_s, "R4", "one-lane size 32", ok_s, 1);
    chk(ok_l, "R4", "one lane each", ok_l, 1);
  endtask

  task automatic t_inactive;
    for (int l = 0; l < LANES; l++) addr_v[l] = (l < 16) ? 32'h6000 + 4*l : 32'hFFFF_0000 - 256*l;
    run_req(32'h0000_FFFF, 0);
    chk_one("R6", 32'h6000, 2'd1, 32'h0000_FFFF);
    for (int l = 0; l < LANES; l++) addr_v[l] = 32'h8000 + 128*l;
    run_req('0, 0);
    chk(got_n == 0, "R6", "empty mask count", got_n, 0);
    chk(first_v == -1, "R6", "no valid", first_v, -1);
    chk(done_c == 1, "R6", "empty done cycle", done_c, 1);
  endtask

  task automatic t_same;
    for (int l = 0; l < LANES; l++) addr_v[l] = 32'h7010;
    run_req('1, 0);
    chk_one("R7", 32'h7000, 2'd0, '1);
    for (int l = 0; l < LANES; l++) addr_v[l] = (l < 16) ? 32'h9004 : 32'h8000;
    run_req('1, 1);
    chk(got_n == 2, "R7", "two groups count", got_n, 2);
    chk(got_base[0] == 32'h8000 && got_lanes[0] == 32'hFFFF_0000, "R7", "group 0",
        got_lanes[0], 32'hFFFF_0000);
    chk(got_base[1] == 32'h9000 && got_lanes[1] == 32'h0000_FFFF, "R7", "group 1",
        got_lanes[1], 32'h0000_FFFF);
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int l = 0; l < LANES; l++) addr_v[l] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_contig();
    t_sizes();
    t_scatter();
    t_inactive();
    t_same();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule